// File: doc/BRIEF.md
# Peripheral Bus Command Channel

This block is the host-facing command channel of a power-management peripheral bus controller. The host CPU sees a small register window. It first loads up to eight bytes of write data into two data words. It then writes a command word, and that write starts exactly one bus transaction. The channel presents the decoded transaction on a request/response port toward a bus-master model. The port carries the opcode, slave ID, address, byte count and write data out, and takes a completion code and read data back.

When the response arrives, the channel posts a four-bit status word. On a successful read it also captures the returned bytes into two read-data words. Bytes above the requested count are zeroed wherever data crosses the block. Only one transaction is in flight at a time. A command written while one is pending is refused, and the refusal is visible in the status word.

A programmable response limit in the config register ends a transaction that never gets an answer. Serial signalling, the bus master itself and host-side locking are outside this block.

Top module: `pbus_cmd_chan`

## Requirements
- R1: After reset, status reads 0, bus_req is low, both read-data words read 0 and config reads the parameter TMO_DEF.
- R2: The command word is decoded as opcode bits 31:27, slave ID bits 23:20, address bits 19:4 and byte count minus one bits 2:0. These fields are presented on the bus port while bus_req is high and stay stable until the transaction ends.
- R3: A command written while idle clears status to 0 and raises bus_req in the next cycle.
- R4: Write byte k (k = 0..3) sits in bits 8k+7:8k of the word at offset 0x10, and byte k+4 sits in the same bits of the word at 0x14. bus_wdata carries byte k in bits 8k+7:8k for k up to the byte count minus one, and zero above that. It is captured when the command is accepted, so later writes to the data words do not change it.
- R5: Opcodes 3 to 6 are non-data commands. For these the bus port shows address 0, byte count field 0 and write data 0, and only the opcode and slave ID are forwarded.
- R6: Completion code 0 (ok), 1 (failure), 2 (denied) and 3 (dropped) post status 0x1, 0x3, 0x5 and 0x9. Status bit 0 is done, bit 1 is failure, bit 2 is denied and bit 3 is dropped. An error bit is never set without done.
- R7: A read opcode (1, 13 or 15) that completes with code 0 loads the read-data words at 0x18 and 0x1C with the returned bytes. Bytes beyond the byte count are zero, and the bytes use the layout of R4.
- R8: Read-data words keep their value after a write opcode, and after any completion code other than 0.
- R9: A command written while busy is ignored. Status shows 0x9 at once, the bus fields are unchanged, and the pending transaction's completion later overwrites status.
- R10: With config = L > 0, a transaction that gets no response within L cycles ends with status 0x3 and bus_req low. With config = 0, the channel waits indefinitely.
- R11: A response that arrives while the channel is idle changes neither status nor read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_addr | input | 5 | Host byte offset in the channel window |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for reg_addr (combinational) |
| bus_req | output | 1 | Transaction pending toward the bus master |
| bus_opcode | output | 5 | Transaction opcode |
| bus_sid | output | 4 | Slave ID |
| bus_addr | output | 16 | Register address in the slave |
| bus_bcnt | output | 3 | Byte count minus one |
| bus_wdata | output | 64 | Write bytes, byte 0 in bits 7:0 |
| bus_resp_valid | input | 1 | One-cycle completion pulse from the bus master |
| bus_resp_code | input | 2 | Completion code: 0 ok, 1 failure, 2 denied, 3 dropped |
| bus_rdata | input | 64 | Read bytes returned with the completion |

## Verification
The bench sweeps every byte count against read, write and zero-write opcodes. At each point it checks that exactly bcnt+1 bytes pass in each direction, so an off-by-one mask would show up as a stray or missing top byte. A command written while busy must post the dropped status without disturbing the bus fields. A design that accepted it would change bus_addr in mid-transaction. The failure, denied and dropped codes are each checked to leave the read words alone, which catches a design that captures data on any completion. The timeout is checked both at a small limit and with the limit set to zero. A response pulse arriving while idle must be ignored; a design that did not check busy would overwrite status.

// File: rtl/pbcc_pkg.sv
package pbcc_pkg;
   localparam int NBYTES = 8;
   localparam int BC_W   = 3;
   localparam int OPC_W  = 5;
   localparam int SID_W  = 4;
   localparam int ADR_W  = 16;
   localparam int STS_W  = 4;

   localparam logic [4:0] OFF_CMD = 5'h00;
   localparam logic [4:0] OFF_CFG = 5'h04;
   localparam logic [4:0] OFF_STS = 5'h08;
   localparam logic [4:0] OFF_WD0 = 5'h10;
   localparam logic [4:0] OFF_WD1 = 5'h14;
   localparam logic [4:0] OFF_RD0 = 5'h18;
   localparam logic [4:0] OFF_RD1 = 5'h1C;

   localparam int ST_DONE = 0;
   localparam int ST_FAIL = 1;
   localparam int ST_DENY = 2;
   localparam int ST_DROP = 3;

   typedef enum logic [1:0] {
      RSP_OK   = 2'd0,
      RSP_FAIL = 2'd1,
      RSP_DENY = 2'd2,
      RSP_DROP = 2'd3
   } rsp_e;

   typedef struct packed {
      logic [OPC_W-1:0] opc;
      logic [SID_W-1:0] sid;
      logic [ADR_W-1:0] addr;
      logic [BC_W-1:0]  bcnt;
   } cmd_t;

   function automatic logic opc_is_read(input logic [OPC_W-1:0] o);
      return (o == 5'd1) || (o == 5'd13) || (o == 5'd15);
   endfunction

   function automatic logic opc_is_nondata(input logic [OPC_W-1:0] o);
      return (o >= 5'd3) && (o <= 5'd6);
   endfunction
endpackage

// File: rtl/pbcc_byte_mask.sv
module pbcc_byte_mask #(
   parameter int NB = 8,
   localparam int LW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic [8*NB-1:0] din,
   input  logic [LW-1:0]   last,
   output logic [8*NB-1:0] dout
);
   if (NB < 1) begin : g_bad_nb
      $error("pbcc_byte_mask: NB must be at least 1");
   end

   for (genvar i = 0; i < NB; i++) begin : g_lane
      assign dout[8*i +: 8] = (i <= int'(last)) ? din[8*i +: 8] : 8'h00;
   end
endmodule

// File: rtl/pbcc_cmd_decode.sv
module pbcc_cmd_decode
   import pbcc_pkg::*;
(
   input  logic [31:0] cmd_word,
   output cmd_t        cmd,
   output logic        nondata
);
   logic unused_bits;
   assign unused_bits = ^{cmd_word[26:24], cmd_word[3]};

   always_comb begin
      cmd.opc  = cmd_word[31:27];
      cmd.sid  = cmd_word[23:20];
      cmd.addr = cmd_word[19:4];
      cmd.bcnt = cmd_word[2:0];
   end

   assign nondata = opc_is_nondata(cmd.opc);
endmodule

// File: rtl/pbcc_seq.sv
module pbcc_seq
   import pbcc_pkg::*;
#(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic             resp_valid,
   input  logic [1:0]       resp_code,
   input  logic [TMO_W-1:0] limit,
   output logic             busy,
   output logic [STS_W-1:0] status,
   output logic             accept,
   output logic             ok_take
);
   logic [TMO_W-1:0] cnt;
   logic             take, tmo_hit;

   assign accept  = cmd_wr && !busy;
   assign take    = busy && resp_valid;
   assign ok_take = take && (resp_code == RSP_OK);
   assign tmo_hit = busy && !resp_valid && (limit != '0) && (cnt == limit - 1'b1);

   function automatic logic [STS_W-1:0] code_to_sts(input logic [1:0] c);
      logic [STS_W-1:0] s;
      s = '0;
      s[ST_DONE] = 1'b1;
      case (c)
         RSP_FAIL: s[ST_FAIL] = 1'b1;
         RSP_DENY: s[ST_DENY] = 1'b1;
         RSP_DROP: s[ST_DROP] = 1'b1;
         default:  ;
      endcase
      return s;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         status <= '0;
      end else if (accept) begin
         busy   <= 1'b1;
         cnt    <= '0;
         status <= '0;
      end else if (take) begin
         busy   <= 1'b0;
         status <= code_to_sts(resp_code);
      end else if (tmo_hit) begin
         busy   <= 1'b0;
         status <= (STS_W'(1) << ST_DONE) | (STS_W'(1) << ST_FAIL);
      end else if (busy) begin
         cnt <= cnt + 1'b1;
         if (cmd_wr) status <= (STS_W'(1) << ST_DONE) | (STS_W'(1) << ST_DROP);
      end
   end

   // R6: error flags only ever appear alongside done
   p_err_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (status[ST_DROP:ST_FAIL] != '0) |-> status[ST_DONE]);

   // R3: an accepted command leaves status clear and the request pending
   p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (status == '0) && busy);

   // R9: a command during a pending transaction only posts the dropped status
   p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_wr && !resp_valid && !tmo_hit) |=> busy && (status == 4'b1001));

   // R10: an expired limit releases the request with failure
   p_tmo_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_hit |=> !busy && (status == 4'b0011));

   // R11: a response while idle leaves status alone
   p_idle_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && resp_valid && !cmd_wr) |=> $stable(status));
endmodule

// File: rtl/pbus_cmd_chan.sv
module pbus_cmd_chan
   import pbcc_pkg::*;
#(
   parameter int TMO_W   = 16,
   parameter int TMO_DEF = 25000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr_en,
   input  logic [4:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        bus_req,
   output logic [4:0]  bus_opcode,
   output logic [3:0]  bus_sid,
   output logic [15:0] bus_addr,
   output logic [2:0]  bus_bcnt,
   output logic [63:0] bus_wdata,
   input  logic        bus_resp_valid,
   input  logic [1:0]  bus_resp_code,
   input  logic [63:0] bus_rdata
);
   localparam int DW = 8 * NBYTES;

   if (TMO_W < 1 || TMO_W > 32) begin : g_bad_tmo_w
      $error("pbus_cmd_chan: TMO_W must be 1..32");
   end
   if (TMO_DEF < 0 || (TMO_W < 32 && TMO_DEF >= (1 << TMO_W))) begin : g_bad_tmo_def
      $error("pbus_cmd_chan: TMO_DEF does not fit TMO_W");
   end

   logic [31:0]      wd0, wd1;
   logic [DW-1:0]    rd_q;
   logic [TMO_W-1:0] cfg_q;
   cmd_t             dec, lat;
   logic             dec_nd;
   logic [DW-1:0]    wd_masked, rd_masked;
   logic             busy, accept, ok_take, cmd_wr;
   logic [STS_W-1:0] status;
   logic [DW-1:0]    lat_wd;

   assign cmd_wr = reg_wr_en && (reg_addr == OFF_CMD);

   pbcc_cmd_decode u_dec (
      .cmd_word (reg_wdata),
      .cmd      (dec),
      .nondata  (dec_nd)
   );

   pbcc_byte_mask #(.NB(NBYTES)) u_wmask (
      .din  ({wd1, wd0}),
      .last (dec.bcnt),
      .dout (wd_masked)
   );

   pbcc_byte_mask #(.NB(NBYTES)) u_rmask (
      .din  (bus_rdata),
      .last (lat.bcnt),
      .dout (rd_masked)
   );

   pbcc_seq #(.TMO_W(TMO_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wr     (cmd_wr),
      .resp_valid (bus_resp_valid),
      .resp_code  (bus_resp_code),
      .limit      (cfg_q),
      .busy       (busy),
      .status     (status),
      .accept     (accept),
      .ok_take    (ok_take)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd0   <= '0;
         wd1   <= '0;
         cfg_q <= TMO_W'(TMO_DEF);
      end else if (reg_wr_en) begin
         case (reg_addr)
            OFF_WD0: wd0   <= reg_wdata;
            OFF_WD1: wd1   <= reg_wdata;
            OFF_CFG: cfg_q <= reg_wdata[TMO_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat    <= '0;
         lat_wd <= '0;
      end else if (accept) begin
         lat.opc  <= dec.opc;
         lat.sid  <= dec.sid;
         lat.addr <= dec_nd ? '0 : dec.addr;
         lat.bcnt <= dec_nd ? '0 : dec.bcnt;
         lat_wd   <= dec_nd ? '0 : wd_masked;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else if (ok_take && opc_is_read(lat.opc)) rd_q <= rd_masked;
   end

   assign bus_req    = busy;
   assign bus_opcode = lat.opc;
   assign bus_sid    = lat.sid;
   assign bus_addr   = lat.addr;
   assign bus_bcnt   = lat.bcnt;
   assign bus_wdata  = lat_wd;

   always_comb begin
      case (reg_addr)
         OFF_CFG: reg_rdata = 32'(cfg_q);
         OFF_STS: reg_rdata = 32'(status);
         OFF_WD0: reg_rdata = wd0;
         OFF_WD1: reg_rdata = wd1;
         OFF_RD0: reg_rdata = rd_q[31:0];
         OFF_RD1: reg_rdata = rd_q[63:32];
         default: reg_rdata = '0;
      endcase
   end

   // R2: bus fields do not move while a transaction is pending
   p_fields_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> $stable(bus_opcode) && $stable(bus_sid) && $stable(bus_addr)
                  && $stable(bus_bcnt) && $stable(bus_wdata));

   // R5: non-data commands forward no address, count or data
   p_nondata_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && opc_is_nondata(bus_opcode)) |->
         (bus_addr == '0) && (bus_bcnt == '0) && (bus_wdata == '0));

   // R8: read data moves only on a successful read completion
   p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && bus_resp_valid && (bus_resp_code == 2'd0) && opc_is_read(bus_opcode))
         |=> $stable(rd_q));
endmodule

// File: tb/pbus_cmd_chan_tb_top.sv
`timescale 1ns/1ps
module pbus_cmd_chan_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [4:0]  reg_addr = 5'h0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic        bus_req;
   logic [4:0]  bus_opcode;
   logic [3:0]  bus_sid;
   logic [15:0] bus_addr;
   logic [2:0]  bus_bcnt;
   logic [63:0] bus_wdata;
   logic        bus_resp_valid = 1'b0;
   logic [1:0]  bus_resp_code = 2'd0;
   logic [63:0] bus_rdata = 64'h0;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   pbus_cmd_chan dut_i (.*);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic respond(input logic [1:0] code, input logic [63:0] data, input int dly);
      repeat (dly) @(negedge clk);
      bus_resp_valid = 1'b1; bus_resp_code = code; bus_rdata = data;
      @(negedge clk);
      bus_resp_valid = 1'b0;
   endtask

   function automatic logic [31:0] cmdw(input int op, input int sid, input int adr, input int bc);
      return (32'(op) << 27) | (32'(sid & 15) << 20) | (32'(adr & 16'hFFFF) << 4) | 32'(bc & 7);
   endfunction

   function automatic logic [63:0] keep(input logic [63:0] d, input int bc);
      logic [63:0] r = 64'h0;
      for (int i = 0; i <= bc; i++) r[8*i +: 8] = d[8*i +: 8];
      return r;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, v1;
      logic [63:0] exp_rd;
      int ops[6] = '{15, 14, 1, 13, 2, 16};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      rd(5'h08, v); chk("R1 status", 64'(v), 64'h0);
      rd(5'h04, v); chk("R1 config", 64'(v), 64'd25000);
      rd(5'h18, v); chk("R1 rdata0", 64'(v), 64'h0);
      rd(5'h1C, v); chk("R1 rdata1", 64'(v), 64'h0);
      chk("R1 bus_req", 64'(bus_req), 64'h0);
      exp_rd = 64'h0;

      // sweep: opcodes x byte counts
      foreach (ops[k]) begin
         for (int bc = 0; bc < 8; bc++) begin
            logic [31:0] w0, w1;
            logic [63:0] rsp;
            int sid, adr;
            w0  = 32'h11223344 + 32'h01010101 * bc + 32'(ops[k]);
            w1  = 32'h8899AABB ^ (32'(ops[k]) << 8) ^ 32'(bc);
            sid = (ops[k] + bc) & 15;
            adr = 16'h0100 * bc + ops[k] * 3 + 16'hA5;
            rsp = {w1, w0} ^ 64'hF0E1D2C3B4A59687 ^ 64'(bc << 20);
            wr(5'h10, w0);
            wr(5'h14, w1);
            wr(5'h00, cmdw(ops[k], sid, adr, bc));
            chk("R3 bus_req", 64'(bus_req), 64'h1);
            rd(5'h08, v); chk("R3 status clear", 64'(v), 64'h0);
            chk("R2 opcode", 64'(bus_opcode), 64'(ops[k]));
            chk("R2 sid", 64'(bus_sid), 64'(sid));
            chk("R2 addr", 64'(bus_addr), 64'(adr & 16'hFFFF));
            chk("R2 bcnt", 64'(bus_bcnt), 64'(bc));
            chk("R4 wdata", bus_wdata, keep({w1, w0}, bc));
            respond(2'd0, rsp, bc % 3);
            rd(5'h08, v); chk("R6 ok status", 64'(v), 64'h1);
            chk("R6 bus_req low", 64'(bus_req), 64'h0);
            if (ops[k] == 1 || ops[k] == 13 || ops[k] == 15) exp_rd = keep(rsp, bc);
            rd(5'h18, v); rd(5'h1C, v1);
            chk("R7 R8 rdata", {v1, v}, exp_rd);
         end
      end

      // R5: non-data command
      wr(5'h10, 32'hDEADBEEF);
      wr(5'h00, cmdw(5, 7, 16'hFFFF, 7));
      chk("R5 opcode", 64'(bus_opcode), 64'd5);
      chk("R5 sid", 64'(bus_sid), 64'd7);
      chk("R5 addr", 64'(bus_addr), 64'h0);
      chk("R5 bcnt", 64'(bus_bcnt), 64'h0);
      chk("R5 wdata", bus_wdata, 64'h0);
      respond(2'd0, 64'h0, 1);

      // R6/R8: error codes on a full-width read
      for (int c = 1; c < 4; c++) begin
         wr(5'h00, cmdw(15, 2, 16'h0420, 7));
         respond(2'(c), 64'h0123456789ABCDEF, 2);
         rd(5'h08, v); chk("R6 error status", 64'(v), 64'((1 << c) | 1));
         rd(5'h18, v); rd(5'h1C, v1);
         chk("R8 rdata kept on error", {v1, v}, exp_rd);
      end

      // R9: command while busy, and R4 snapshot
      wr(5'h10, 32'hCAFEF00D);
      wr(5'h00, cmdw(15, 3, 16'h0333, 1));
      wr(5'h00, cmdw(14, 9, 16'h0777, 5));
      rd(5'h08, v); chk("R9 dropped status", 64'(v), 64'h9);
      chk("R9 addr kept", 64'(bus_addr), 64'h0333);
      chk("R9 opcode kept", 64'(bus_opcode), 64'd15);
      chk("R9 still busy", 64'(bus_req), 64'h1);
      wr(5'h10, 32'h12345678);
      chk("R4 snapshot", bus_wdata, 64'h000000000000F00D);
      respond(2'd0, 64'h1111_2222_3333_4444, 1);
      rd(5'h08, v); chk("R9 completion overwrites", 64'(v), 64'h1);
      exp_rd = 64'h4444;
      rd(5'h18, v); rd(5'h1C, v1);
      chk("R7 two-byte read", {v1, v}, exp_rd);

      // R10: timeout
      wr(5'h04, 32'd4);
      rd(5'h04, v); chk("R10 config", 64'(v), 64'd4);
      wr(5'h00, cmdw(14, 1, 16'h0010, 0));
      repeat (2) @(negedge clk);
      chk("R10 pending before limit", 64'(bus_req), 64'h1);
      rd(5'h08, v); chk("R10 status before limit", 64'(v), 64'h0);
      repeat (10) @(negedge clk);
      chk("R10 released", 64'(bus_req), 64'h0);
      rd(5'h08, v); chk("R10 timeout status", 64'(v), 64'h3);
      wr(5'h04, 32'd0);
      wr(5'h00, cmdw(14, 1, 16'h0010, 0));
      repeat (60) @(negedge clk);
      chk("R10 zero limit waits", 64'(bus_req), 64'h1);
      respond(2'd0, 64'h0, 0);
      rd(5'h08, v); chk("R10 late ok", 64'(v), 64'h1);

      // R11: response while idle
      respond(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1);
      rd(5'h08, v); chk("R11 status kept", 64'(v), 64'h1);
      rd(5'h18, v); rd(5'h1C, v1);
      chk("R11 rdata kept", {v1, v}, exp_rd);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule